// File: doc/BRIEF.md
# Mixed-Width Dual-Port Synchronous RAM

This block is a 4096-bit random-access memory with two fully independent ports. Each port has its own clock, synchronous reset, enable, write enable, address and data buses. The data width of each port is a parameter chosen from 1, 2, 4, 8 or 16 bits, and the port's address range grows or shrinks so that it always covers all 4096 bits. Both ports see one bit array. A word written through a wide port can be read back piece by piece through a narrow port, and the reverse also works.

A word of width W at address N occupies array bits N*W up to N*W+W-1, so lower addresses map to lower bits. Every input is captured on the port's rising clock edge. The read result appears on the port's registered output one edge later. While a port writes, its output shows the value being written. Two ports may read and write at the same time. A read that collides with a write from the other port on the same edge returns the contents from before that write. If both ports write the same bit on the same edge, the result is undefined.

Top module: `mixwidth_dpram`

## Requirements
- R1: The array holds 4096 bits. A port of width W (1, 2, 4, 8 or 16) has 4096/W addresses and an address bus of log2(4096/W) bits. The highest address of a port reaches the topmost bits of the array.
- R2: A word of width W at address N maps to array bits N*W through N*W+W-1, with word bit 0 on array bit N*W. Data written at one width reads back correctly at another width.
- R3: Address, data, enable and write enable take effect only on the port's rising clock edge. The output changes one edge after a read request, and an address change between edges leaves the output unchanged.
- R4: When a port writes (enable=1, write enable=1), its output register takes the written data on the same edge.
- R5: While a port's enable is 0, its output register holds its value. No write happens through that port, even if its write enable is 1.
- R6: When one port reads bits that the other port writes on the same edge, the read returns the contents from before that write. A later read returns the new data.
- R7: Writes from both ports on the same edge to disjoint bits both land in the array.
- R8: A synchronous active-high reset on a port clears that port's output register to zero and leaves the array contents unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset, active high |
| en_a | input | 1 | Port A enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | log2(4096/WIDTH_A) | Port A word address |
| din_a | input | WIDTH_A | Port A write data |
| dout_a | output | WIDTH_A | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset, active high |
| en_b | input | 1 | Port B enable |
| we_b | input | 1 | Port B write enable |
| addr_b | input | log2(4096/WIDTH_B) | Port B word address |
| din_b | input | WIDTH_B | Port B write data |
| dout_b | output | WIDTH_B | Port B registered read data |

## Verification
The bench builds the block with WIDTH_A=16 and WIDTH_B=4, so four narrow words fall inside each wide word. This makes it possible to check the nibble order within a wide word, partial overwrites through the narrow port, and the top nibble of the array at both ports' last addresses. Both clock inputs are driven from one clock, so a read and a write from different ports can land on the same edge. This lets the bench check that a colliding read returns old data and that disjoint writes on the same edge both land.

// File: rtl/mixwidth_dpram_pkg.sv
package mixwidth_dpram_pkg;

  localparam int unsigned ARRAY_BITS = 4096;

  // number of words a port of the given width addresses
  function automatic int unsigned port_depth(input int unsigned width);
    return ARRAY_BITS / width;
  endfunction

  // address bus width for a port of the given width
  function automatic int unsigned port_addr_w(input int unsigned width);
    return $clog2(ARRAY_BITS / width);
  endfunction

endpackage

// File: rtl/mixwidth_dpram_bank.sv
// Single-writer bit store. The two banks together hold the array; a bit's
// value is the XOR of its copies in both banks, so each bank has one clock.
module mixwidth_dpram_bank #(
  parameter int unsigned BITS   = 4096,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned BW    = $clog2(BITS)
) (
  input  logic              clk,
  input  logic              wr,
  input  logic [BW-1:0]     base,
  input  logic [DATA_W-1:0] wdata,
  output logic [BITS-1:0]   store
);

  always_ff @(posedge clk) begin
    if (wr) store[base +: DATA_W] <= wdata;
  end

endmodule

// File: rtl/mixwidth_dpram_port.sv
module mixwidth_dpram_port #(
  parameter int unsigned BITS   = 4096,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned AW    = $clog2(BITS / DATA_W),
  localparam int unsigned BW    = $clog2(BITS),
  localparam int unsigned LOG2W = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              we,
  input  logic [AW-1:0]     addr,
  input  logic [DATA_W-1:0] din,
  input  logic [BITS-1:0]   peer_store,
  output logic [BITS-1:0]   own_store,
  output logic [DATA_W-1:0] dout
);

  logic [BW-1:0]     base;
  logic [DATA_W-1:0] peer_slice;
  logic [DATA_W-1:0] own_slice;
  logic              wr;

  assign base       = BW'(addr) << LOG2W;
  assign peer_slice = peer_store[base +: DATA_W];
  assign own_slice  = own_store[base +: DATA_W];
  assign wr         = en & we;

  mixwidth_dpram_bank #(
    .BITS   (BITS),
    .DATA_W (DATA_W)
  ) bank_i (
    .clk   (clk),
    .wr    (wr),
    .base  (base),
    .wdata (din ^ peer_slice),
    .store (own_store)
  );

  // write-first output register; held while disabled
  always_ff @(posedge clk) begin
    if (rst) begin
      dout <= '0;
    end else if (en) begin
      if (we) dout <= din;
      else    dout <= own_slice ^ peer_slice;
    end
  end

  AST_WRITE_ECHO: assert property (@(posedge clk) disable iff (rst)
    (en && we) |=> (dout == $past(din))); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(dout)); // R5

  AST_IDLE_NO_STORE: assert property (@(posedge clk) disable iff (rst)
    !(en && we) |=> $stable(own_store)); // R5

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (dout == '0)); // R8

endmodule

// File: rtl/mixwidth_dpram.sv
module mixwidth_dpram
  import mixwidth_dpram_pkg::*;
#(
  parameter int unsigned WIDTH_A = 8,
  parameter int unsigned WIDTH_B = 2,
  localparam int unsigned AW_A   = port_addr_w(WIDTH_A),
  localparam int unsigned AW_B   = port_addr_w(WIDTH_B)
) (
  input  logic               clk_a,
  input  logic               rst_a,
  input  logic               en_a,
  input  logic               we_a,
  input  logic [AW_A-1:0]    addr_a,
  input  logic [WIDTH_A-1:0] din_a,
  output logic [WIDTH_A-1:0] dout_a,
  input  logic               clk_b,
  input  logic               rst_b,
  input  logic               en_b,
  input  logic               we_b,
  input  logic [AW_B-1:0]    addr_b,
  input  logic [WIDTH_B-1:0] din_b,
  output logic [WIDTH_B-1:0] dout_b
);

  logic [ARRAY_BITS-1:0] store_a;
  logic [ARRAY_BITS-1:0] store_b;

  mixwidth_dpram_port #(
    .BITS   (ARRAY_BITS),
    .DATA_W (WIDTH_A)
  ) port_a_i (
    .clk        (clk_a),
    .rst        (rst_a),
    .en         (en_a),
    .we         (we_a),
    .addr       (addr_a),
    .din        (din_a),
    .peer_store (store_b),
    .own_store  (store_a),
    .dout       (dout_a)
  );

  mixwidth_dpram_port #(
    .BITS   (ARRAY_BITS),
    .DATA_W (WIDTH_B)
  ) port_b_i (
    .clk        (clk_b),
    .rst        (rst_b),
    .en         (en_b),
    .we         (we_b),
    .addr       (addr_b),
    .din        (din_b),
    .peer_store (store_a),
    .own_store  (store_b),
    .dout       (dout_b)
  );

endmodule

// File: tb/mixwidth_dpram_tb_top.sv
module mixwidth_dpram_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WA = 16;
  localparam int WB = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en_a = 0, we_a = 0, en_b = 0, we_b = 0;
  logic [7:0]  addr_a = '0;
  logic [9:0]  addr_b = '0;
  logic [15:0] din_a = '0;
  logic [3:0]  din_b = '0;
  logic [15:0] dout_a;
  logic [3:0]  dout_b;

  int checks = 0;
  int failures = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mixwidth_dpram #(.WIDTH_A(WA), .WIDTH_B(WB)) dut_i (
    .clk_a(clk), .rst_a(rst), .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
    .din_a(din_a), .dout_a(dout_a),
    .clk_b(clk), .rst_b(rst), .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
    .din_b(din_b), .dout_b(dout_b)
  );

  // fields: [45] port (0=A,1=B) [44] write [43:32] addr [31:16] data [15:0] expected
  localparam int NVEC = 11;
  localparam logic [45:0] VEC [NVEC] = '{
    {1'b0, 1'b1, 12'd3,    16'hABCD, 16'hABCD}, // R4 write echo
    {1'b1, 1'b0, 12'd12,   16'h0000, 16'h000D}, // R2 low nibble
    {1'b1, 1'b0, 12'd15,   16'h0000, 16'h000A}, // R2 high nibble
    {1'b1, 1'b1, 12'd13,   16'h0005, 16'h0005}, // R4 narrow write
    {1'b0, 1'b0, 12'd3,    16'h0000, 16'hAB5D}, // R2 partial overwrite
    {1'b0, 1'b1, 12'd0,    16'h1230, 16'h1230}, // R4
    {1'b1, 1'b1, 12'd0,    16'h000F, 16'h000F}, // R4
    {1'b0, 1'b0, 12'd0,    16'h0000, 16'h123F}, // R2
    {1'b0, 1'b1, 12'd255,  16'h8421, 16'h8421}, // R1 last wide address
    {1'b1, 1'b0, 12'd1023, 16'h0000, 16'h0008}, // R1 last narrow address
    {1'b1, 1'b0, 12'd1020, 16'h0000, 16'h0001}  // R1
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic set_a(input logic e, input logic w, input logic [7:0] a, input logic [15:0] d);
    en_a = e; we_a = w; addr_a = a; din_a = d;
  endtask

  task automatic set_b(input logic e, input logic w, input logic [9:0] a, input logic [3:0] d);
    en_b = e; we_b = w; addr_b = a; din_b = d;
  endtask

  task automatic idle();
    set_a(0, 0, addr_a, din_a);
    set_b(0, 0, addr_b, din_b);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    failures++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset A", dout_a, 16'h0000);
    check("R8 reset B", {12'h0, dout_b}, 16'h0000);
    rst = 1'b0;

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      idle();
      if (VEC[i][45]) set_b(1, VEC[i][44], VEC[i][41:32], VEC[i][19:16]);
      else            set_a(1, VEC[i][44], VEC[i][39:32], VEC[i][31:16]);
      @(negedge clk);
      idle();
      if (VEC[i][45]) check($sformatf("R2 vector %0d B", i), {12'h0, dout_b}, VEC[i][15:0]);
      else            check($sformatf("R2 vector %0d A", i), dout_a, VEC[i][15:0]);
    end

    // R5: disabled port holds output and ignores write enable
    set_b(0, 1, 10'd1020, 4'h0);
    @(negedge clk);
    check("R5 hold", {12'h0, dout_b}, 16'h0001);
    idle();
    set_b(1, 0, 10'd1020, 4'h0);
    @(negedge clk);
    check("R5 no write", {12'h0, dout_b}, 16'h0001);
    idle();

    // R3: address change between edges has no effect until the edge
    set_b(1, 0, 10'd1023, 4'h0);
    #(CLK_PERIOD/4);
    check("R3 before edge", {12'h0, dout_b}, 16'h0001);
    @(negedge clk);
    check("R3 after edge", {12'h0, dout_b}, 16'h0008);
    idle();

    // R6: read collides with the other port's write -> old data
    set_a(1, 1, 8'd5, 16'h9999);
    @(negedge clk);
    set_a(1, 1, 8'd5, 16'h1111);
    set_b(1, 0, 10'd20, 4'h0);
    @(negedge clk);
    check("R6 old data", {12'h0, dout_b}, 16'h0009);
    check("R4 collide writer", dout_a, 16'h1111);
    idle();
    set_b(1, 0, 10'd20, 4'h0);
    @(negedge clk);
    check("R6 new data later", {12'h0, dout_b}, 16'h0001);
    idle();

    // R7: both ports write disjoint bits on the same edge
    set_a(1, 1, 8'd7, 16'h0000);
    @(negedge clk);
    set_a(1, 1, 8'd6, 16'h7777);
    set_b(1, 1, 10'd28, 4'hC);
    @(negedge clk);
    idle();
    set_a(1, 0, 8'd7, 16'h0);
    @(negedge clk);
    check("R7 port B write landed", dout_a, 16'h000C);
    set_a(1, 0, 8'd6, 16'h0);
    @(negedge clk);
    check("R7 port A write landed", dout_a, 16'h7777);
    idle();

    // R8: mid-run reset clears outputs, keeps contents
    rst = 1'b1;
    @(negedge clk);
    check("R8 clear A", dout_a, 16'h0000);
    check("R8 clear B", {12'h0, dout_b}, 16'h0000);
    rst = 1'b0;
    set_a(1, 0, 8'd6, 16'h0);
    @(negedge clk);
    check("R8 contents kept", dout_a, 16'h7777);
    idle();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule